// File: doc/BRIEF.md
# Parallel Radix-51 Limb Carry Reducer

This block takes a field element for arithmetic modulo 2^255-19 and returns a partially reduced copy of it. The element is five 64-bit limbs, and limb i carries weight 2^(51·i), so five limbs span 255 bits. After an addition or a subtraction the limbs can grow past 51 bits, and the element then has to be brought back into range before it can feed a multiplier.

A sequential carry chain would ripple through the limbs one at a time. This block avoids that. In one step it splits every limb into a 51-bit body and a 13-bit carry (bits 63..51). It then gives each body the carry of the limb below it. The carry out of the top limb wraps around into limb 0 after a multiply by 19, because 2^255 ≡ 19 (mod p). The multiply is built from shifts and adds.

The result may stay slightly redundant, with each limb below 2^52, but it is always a legal multiplier input. The output is registered, so each input strobe produces a result strobe one cycle later. Canonical reduction below p is not done here.

Top module: `rdx51_carry_reduce`

## Requirements
- R1: `res_valid` is high in the cycle after each cycle in which `src_valid` is high, and low in the cycle after each cycle in which `src_valid` is low.
- R2: For i = 1..4, the output limb i equals bits [50:0] of input limb i plus bits [63:51] of input limb i-1, taken as an unsigned number. Limb i occupies bits [64·i+63 : 64·i] of both limb buses.
- R3: Output limb 0 equals bits [50:0] of input limb 0 plus 19 times bits [63:51] of input limb 4.
- R4: Every output limb presented with `res_valid` is below 2^52, so bits [63:52] of each limb are zero.
- R5: The weighted sum Σ limb_i·2^(51·i) of the output is congruent to that of the input modulo 2^255-19.
- R6: While `src_valid` is low, `src_limbs` is ignored and `res_limbs` holds its last value.
- R7: After reset, `res_valid` is low and `res_limbs` is all zero.
- R8: An input whose limbs are all below 2^51 is returned unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_valid | input | 1 | Input element present this cycle |
| src_limbs | input | 320 | Five 64-bit input limbs, limb 0 in the low bits |
| res_valid | output | 1 | Reduced element present |
| res_limbs | output | 320 | Five 64-bit reduced limbs, limb 0 in the low bits |

## Verification
The bench sweeps every 13-bit value of the top-limb carry. This exposes a wrong fold constant, a shift-add term that was dropped, or a fold product that was truncated: limb 0 would be off by a multiple of the carry, and the modular sum would stop matching. A ternary sweep sets each limb to zero, to 2^51-1 or to all ones. These vectors catch a carry routed to the wrong neighbour, a mask that is one bit off, and a limb that overflows past 2^52 at the extremes. Already reduced inputs must come back unchanged, which shows up any carry that has been invented. After each accepted vector the bench drives changed data with the strobe low, and a design that loads regardless of the strobe would show the new data.

// File: rtl/rdx_pkg.sv
package rdx_pkg;
  localparam int DEF_LIMB_W  = 64;
  localparam int DEF_RADIX   = 51;
  localparam int DEF_N_LIMBS = 5;
  localparam int DEF_FOLD_K  = 19;
endpackage

// File: rtl/rdx_split.sv
// Cuts every limb into its radix-sized body and the carry above it, all limbs at once.
module rdx_split #(
  parameter int LIMB_W  = 64,
  parameter int RADIX   = 51,
  parameter int N_LIMBS = 5,
  localparam int CARRY_W = LIMB_W - RADIX
) (
  input  logic [N_LIMBS*LIMB_W-1:0]  limbs_i,
  output logic [N_LIMBS*RADIX-1:0]   body_o,
  output logic [N_LIMBS*CARRY_W-1:0] carry_o
);
  for (genvar g = 0; g < N_LIMBS; g++) begin : g_limb
    assign body_o[g*RADIX +: RADIX]     = limbs_i[g*LIMB_W +: RADIX];
    assign carry_o[g*CARRY_W +: CARRY_W] = limbs_i[g*LIMB_W + RADIX +: CARRY_W];
  end
endmodule

// File: rtl/rdx_fold.sv
// Constant multiply of the wrap-around carry, built from one shifted copy per set bit of K.
module rdx_fold #(
  parameter int IN_W = 13,
  parameter int K    = 19,
  localparam int K_BITS = $clog2(K + 1),
  localparam int OUT_W  = IN_W + K_BITS
) (
  input  logic [IN_W-1:0]  carry_i,
  output logic [OUT_W-1:0] prod_o
);
  localparam logic [K_BITS-1:0] KV = K_BITS'(K);

  logic [OUT_W-1:0] term [K_BITS];

  for (genvar b = 0; b < K_BITS; b++) begin : g_term
    if (KV[b]) begin : g_on
      assign term[b] = OUT_W'(carry_i) << b;
    end else begin : g_off
      assign term[b] = '0;
    end
  end

  always_comb begin
    prod_o = '0;
    for (int b = 0; b < K_BITS; b++) prod_o = prod_o + term[b];
  end
endmodule

// File: rtl/rdx_merge.sv
// Adds to each body the carry of its lower neighbour; limb 0 takes the folded top carry.
module rdx_merge #(
  parameter int LIMB_W  = 64,
  parameter int RADIX   = 51,
  parameter int N_LIMBS = 5,
  parameter int FOLD_W  = 18,
  localparam int CARRY_W = LIMB_W - RADIX
) (
  input  logic [N_LIMBS*RADIX-1:0]   body_i,
  input  logic [N_LIMBS*CARRY_W-1:0] carry_i,
  input  logic [FOLD_W-1:0]          fold_i,
  output logic [N_LIMBS*LIMB_W-1:0]  limbs_o
);
  assign limbs_o[0 +: LIMB_W] = LIMB_W'(body_i[0 +: RADIX]) + LIMB_W'(fold_i);

  for (genvar g = 1; g < N_LIMBS; g++) begin : g_limb
    assign limbs_o[g*LIMB_W +: LIMB_W] = LIMB_W'(body_i[g*RADIX +: RADIX])
                                       + LIMB_W'(carry_i[(g-1)*CARRY_W +: CARRY_W]);
  end
endmodule

// File: rtl/rdx51_carry_reduce.sv
module rdx51_carry_reduce
  import rdx_pkg::*;
#(
  parameter int LIMB_W  = DEF_LIMB_W,
  parameter int RADIX   = DEF_RADIX,
  parameter int N_LIMBS = DEF_N_LIMBS,
  parameter int FOLD_K  = DEF_FOLD_K,
  localparam int CARRY_W = LIMB_W - RADIX,
  localparam int FOLD_W  = CARRY_W + $clog2(FOLD_K + 1),
  localparam int BUS_W   = N_LIMBS * LIMB_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             src_valid,
  input  logic [BUS_W-1:0] src_limbs,
  output logic             res_valid,
  output logic [BUS_W-1:0] res_limbs
);
  logic [N_LIMBS*RADIX-1:0]   body;
  logic [N_LIMBS*CARRY_W-1:0] carry;
  logic [FOLD_W-1:0]          fold;
  logic [BUS_W-1:0]           merged;

  rdx_split #(.LIMB_W(LIMB_W), .RADIX(RADIX), .N_LIMBS(N_LIMBS)) u_split (
    .limbs_i(src_limbs), .body_o(body), .carry_o(carry)
  );

  rdx_fold #(.IN_W(CARRY_W), .K(FOLD_K)) u_fold (
    .carry_i(carry[(N_LIMBS-1)*CARRY_W +: CARRY_W]), .prod_o(fold)
  );

  rdx_merge #(.LIMB_W(LIMB_W), .RADIX(RADIX), .N_LIMBS(N_LIMBS), .FOLD_W(FOLD_W)) u_merge (
    .body_i(body), .carry_i(carry), .fold_i(fold), .limbs_o(merged)
  );

  // Next-state and register processes, load enable is the input strobe.
  logic             valid_d;
  logic [BUS_W-1:0] limbs_d;

  always_comb begin
    valid_d = src_valid;
    limbs_d = src_valid ? merged : res_limbs;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_limbs <= '0;
    end else begin
      res_valid <= valid_d;
      res_limbs <= limbs_d;
    end
  end

  // Observation helpers for the properties.
  logic src_small;
  logic res_bounded;
  always_comb begin
    src_small   = 1'b1;
    res_bounded = 1'b1;
    for (int i = 0; i < N_LIMBS; i++) begin
      if (src_limbs[i*LIMB_W + RADIX +: CARRY_W] != '0) src_small = 1'b0;
      if (res_limbs[i*LIMB_W + RADIX + 1 +: CARRY_W - 1] != '0) res_bounded = 1'b0;
    end
  end

  p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
    src_valid |=> res_valid);
  p_valid_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> !res_valid);
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> res_bounded);
  p_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |=> $stable(res_limbs));
  p_passthru_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (src_valid && src_small) |=> (res_limbs == $past(src_limbs)));
endmodule

// File: tb/rdx51_carry_reduce_bench.sv
`timescale 1ns/1ps
module rdx51_carry_reduce_bench;
  localparam int N  = 5;
  localparam int W  = 64;
  localparam int R  = 51;
  localparam int BW = N * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          src_valid;
  logic [BW-1:0] src_limbs;
  logic          res_valid;
  logic [BW-1:0] res_limbs;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;
  logic [63:0] seed = 64'h9E37_79B9_7F4A_7C15;

  always #2.5 clk = ~clk;

  rdx51_carry_reduce u_rdx51_carry_reduce (
    .clk(clk), .rst_n(rst_n), .src_valid(src_valid), .src_limbs(src_limbs),
    .res_valid(res_valid), .res_limbs(res_limbs)
  );

  function automatic logic [63:0] rnd();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 7);
    seed = seed ^ (seed << 17);
    return seed;
  endfunction

  // Expected limbs straight from R2 and R3.
  function automatic logic [BW-1:0] model(input logic [BW-1:0] v);
    logic [BW-1:0] o;
    logic [63:0] low, cin;
    for (int i = 0; i < N; i++) begin
      low = {13'd0, v[i*W +: R]};
      if (i == 0) cin = 64'(v[(N-1)*W + R +: 13]) * 64'd19;
      else        cin = 64'(v[(i-1)*W + R +: 13]);
      o[i*W +: W] = low + cin;
    end
    return o;
  endfunction

  function automatic logic [319:0] value_mod_p(input logic [BW-1:0] v);
    logic [319:0] acc, p;
    p = (320'd1 << 255) - 320'd19;
    acc = '0;
    for (int i = 0; i < N; i++) acc = acc + ({256'd0, v[i*W +: W]} << (R * i));
    return acc % p;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [319:0] got, input logic [319:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic run(input logic [BW-1:0] v, input bit pass_through);
    logic [BW-1:0] exp, held;
    bit bound;
    @(negedge clk);
    src_valid = 1'b1;
    src_limbs = v;
    @(negedge clk);
    src_valid = 1'b0;
    src_limbs = ~v;
    exp = model(v);
    chk(res_valid == 1'b1, "R1 valid after strobe", 320'(res_valid), 320'd1);
    for (int i = 1; i < N; i++)
      chk(res_limbs[i*W +: W] == exp[i*W +: W], "R2 upper limb", 320'(res_limbs[i*W +: W]), 320'(exp[i*W +: W]));
    chk(res_limbs[0 +: W] == exp[0 +: W], "R3 limb0 fold", 320'(res_limbs[0 +: W]), 320'(exp[0 +: W]));
    bound = 1'b1;
    for (int i = 0; i < N; i++) if (res_limbs[i*W +: W] >= (64'd1 << 52)) bound = 1'b0;
    chk(bound, "R4 limb below 2^52", res_limbs, 320'd0);
    chk(value_mod_p(res_limbs) == value_mod_p(v), "R5 congruence", value_mod_p(res_limbs), value_mod_p(v));
    if (pass_through) chk(res_limbs == v, "R8 reduced input unchanged", res_limbs, v);
    held = res_limbs;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 valid idle", 320'(res_valid), 320'd0);
    chk(res_limbs == held, "R6 hold while idle", res_limbs, held);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [BW-1:0] v;
    logic [63:0] pat [3];
    rst_n     = 1'b0;
    src_valid = 1'b0;
    src_limbs = '0;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R7 reset valid", 320'(res_valid), 320'd0);
    chk(res_limbs == '0, "R7 reset limbs", res_limbs, 320'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(res_valid == 1'b0, "R7 valid after release", 320'(res_valid), 320'd0);

    // R3: every value of the top-limb carry.
    for (int c = 0; c < 8192; c++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = rnd();
      v[(N-1)*W + R +: 13] = 13'(c);
      run(v, 1'b0);
    end

    // R2, R4: ternary extremes on every limb.
    pat[0] = 64'd0;
    pat[1] = (64'd1 << R) - 64'd1;
    pat[2] = '1;
    for (int k = 0; k < 243; k++) begin
      int t = k;
      for (int i = 0; i < N; i++) begin
        v[i*W +: W] = pat[t % 3];
        t = t / 3;
      end
      run(v, 1'b0);
    end

    // R8: already reduced inputs.
    for (int k = 0; k < 200; k++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = rnd() & ((64'd1 << R) - 64'd1);
      run(v, 1'b1);
    end

    // General random inputs.
    for (int k = 0; k < 300; k++) begin
      for (int i = 0; i < N; i++) v[i*W +: W] = rnd();
      run(v, 1'b0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule